// File: doc/BRIEF.md
# Port I/O Window Bridge with Byte-Order Swap

This block sits on a processor's memory bus and claims a fixed 64 KB window of physical addresses. Each access that lands in the window is turned into a single port I/O operation on a bus with 16-bit addresses. The port address is the low 16 bits of the processor address. The operation is 8, 16 or 32 bits wide, matching the size of the processor access. Accesses outside the window, or with an unsupported size code, are left alone for other decoders to claim.

When the block is configured for a big-endian processor, the bytes of 16-bit and 32-bit accesses are reversed on the way out (write data) and on the way back (read data). Single-byte accesses always pass straight through. The byte-order choice is a strap input that is captured while reset is held, so changing it later has no effect.

Only one access is in flight at a time. The bridge raises a port request and keeps the address, size, direction and write data steady until the port side acknowledges. On the cycle after the acknowledge it drops the request and pulses a completion strobe, with the read data alongside it.

Top module: `pio_window_bridge`

## Requirements
- R1: `cpu_claim` is high only for a request whose address is in 0x14000000..0x1400FFFF, with a legal size, while the bridge is idle. A request outside that range is never claimed and never produces `io_req`.
- R2: A claimed access produces `io_req` on the next cycle with the following fields:
  - `io_addr` equal to the processor address ANDed with 0xFFFF.
  - `io_size` equal to `cpu_size`, where 0 is byte, 1 is halfword and 2 is word.
  - `io_we` equal to `cpu_we`.
- R3: For a byte access (size 0), the data is not swapped whatever the byte-order setting:
  - `io_wdata` is `{24'b0, wdata[7:0]}`.
  - `cpu_rdata` is `{24'b0, io_rdata[7:0]}`.
- R4: In little-endian mode, data passes through unswapped. A halfword carries bits [15:0] with the upper 16 bits zero; a word carries all 32 bits.
- R5: In big-endian mode, a halfword write drives `io_wdata = {16'b0, wdata[7:0], wdata[15:8]}`. A halfword read returns `{16'b0, io_rdata[7:0], io_rdata[15:8]}`.
- R6: In big-endian mode, a word access reverses all four bytes in both directions.
- R7: While `io_req` is high and `io_ack` is low, `io_req`, `io_addr`, `io_size`, `io_we` and `io_wdata` stay unchanged on the next cycle.
- R8: The cycle after `io_req` and `io_ack` are both high, `cpu_done` is high for one cycle and `io_req` is low. For a read, `cpu_rdata` holds the converted read data; for a write, it is zero.
- R9: Size code 3 is never claimed.
- R10: The byte-order setting is the value of `cfg_big_endian` (1 = big-endian) while `rst_n` is low. Later changes to `cfg_big_endian` have no effect.
- R11: While an access is outstanding, a new request is not claimed, even if it falls inside the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_big_endian | input | 1 | Byte-order strap, captured during reset |
| cpu_req | input | 1 | Processor access request |
| cpu_addr | input | 32 | Processor physical address |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 illegal |
| cpu_wdata | input | 32 | Write data, right-aligned |
| cpu_claim | output | 1 | Bridge accepts this request |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read data, valid with cpu_done |
| io_req | output | 1 | Port operation request |
| io_we | output | 1 | Port operation direction |
| io_addr | output | 16 | Port address |
| io_size | output | 2 | Port operation size |
| io_wdata | output | 32 | Port write data |
| io_ack | input | 1 | Port operation complete |
| io_rdata | input | 32 | Port read data, valid with io_ack |

## Verification
The hardest case to reach from the ports is a new in-window request arriving while an earlier access is still waiting for its acknowledge. The bench stretches the acknowledge by a random number of cycles and, during that wait, offers a fresh in-window request. It then checks that this request is refused and that the outstanding port fields do not move.

Changing the byte-order strap after reset is driven on purpose, to show that the captured setting persists. Random addresses are skewed toward the window and toward the words just below and just above its edges.

// File: rtl/pio_window_bridge.sv
module pio_window_bridge #(
  parameter int              ADDR_W   = 32,
  parameter int              WIN_AW   = 16,
  parameter int              PORT_AW  = 16,
  parameter logic [31:0]     WIN_BASE = 32'h1400_0000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_big_endian,
  input  logic               cpu_req,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic               cpu_we,
  input  logic [1:0]         cpu_size,
  input  logic [31:0]        cpu_wdata,
  output logic               cpu_claim,
  output logic               cpu_done,
  output logic [31:0]        cpu_rdata,
  output logic               io_req,
  output logic               io_we,
  output logic [PORT_AW-1:0] io_addr,
  output logic [1:0]         io_size,
  output logic [31:0]        io_wdata,
  input  logic               io_ack,
  input  logic [31:0]        io_rdata
);
  localparam int TAG_W = ADDR_W - WIN_AW;
  localparam logic [TAG_W-1:0] WIN_TAG = WIN_BASE[ADDR_W-1:WIN_AW];

  logic big_q;
  logic busy_q;

  function automatic logic [31:0] lanes(input logic [1:0] sz, input logic be, input logic [31:0] d);
    case (sz)
      2'd0:    lanes = {24'b0, d[7:0]};
      2'd1:    lanes = be ? {16'b0, d[7:0], d[15:8]} : {16'b0, d[15:0]};
      default: lanes = be ? {d[7:0], d[15:8], d[23:16], d[31:24]} : d;
    endcase
  endfunction

  wire in_win = cpu_addr[ADDR_W-1:WIN_AW] == WIN_TAG;
  assign cpu_claim = cpu_req && in_win && (cpu_size != 2'd3) && !busy_q;
  assign io_req = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) big_q <= cfg_big_endian;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      cpu_done  <= 1'b0;
      cpu_rdata <= '0;
      io_we     <= 1'b0;
      io_addr   <= '0;
      io_size   <= '0;
      io_wdata  <= '0;
    end else begin
      cpu_done <= 1'b0;
      if (cpu_claim) begin
        busy_q   <= 1'b1;
        io_we    <= cpu_we;
        io_addr  <= cpu_addr[PORT_AW-1:0];
        io_size  <= cpu_size;
        io_wdata <= cpu_we ? lanes(cpu_size, big_q, cpu_wdata) : 32'b0;
      end else if (busy_q && io_ack) begin
        busy_q    <= 1'b0;
        cpu_done  <= 1'b1;
        cpu_rdata <= io_we ? 32'b0 : lanes(io_size, big_q, io_rdata);
      end
    end
  end

  a_r7_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    io_req && !io_ack |=> io_req && $stable(io_addr) && $stable(io_size) && $stable(io_we) && $stable(io_wdata));
  a_r8_done_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    io_req && io_ack |=> cpu_done && !io_req);
  a_r8_done_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |-> $past(io_ack));
  a_r9_no_bad_size: assert property (@(posedge clk) disable iff (!rst_n)
    io_req |-> io_size != 2'd3);
  a_r3_byte_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    io_req && io_size == 2'd0 |-> io_wdata[31:8] == 24'b0);
  a_r11_single_access: assert property (@(posedge clk) disable iff (!rst_n)
    io_req |-> !cpu_claim);
  a_r1_claim_starts_port: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_claim |=> io_req);
endmodule

// File: tb/sim_pio_window_bridge.sv
module sim_pio_window_bridge;
  logic clk = 0, rst_n = 0, cfg_big_endian = 0;
  logic cpu_req = 0, cpu_we = 0, io_ack = 0;
  logic [31:0] cpu_addr = 0, cpu_wdata = 0, io_rdata = 0;
  logic [1:0] cpu_size = 0;
  logic cpu_claim, cpu_done, io_req, io_we;
  logic [31:0] cpu_rdata, io_wdata;
  logic [15:0] io_addr;
  logic [1:0] io_size;
  int checks = 0, fails = 0;
  bit mode_be = 0;

  always #2 clk = ~clk;

  pio_window_bridge u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] conv(input logic [1:0] sz, input bit be, input logic [31:0] d);
    if (sz == 0) return {24'b0, d[7:0]};
    if (sz == 1) return be ? {16'b0, d[7:0], d[15:8]} : {16'b0, d[15:0]};
    return be ? {d[7:0], d[15:8], d[23:16], d[31:24]} : d;
  endfunction

  function automatic string tag_of(input logic [1:0] sz, input bit be);
    if (sz == 0) return "R3";
    if (!be) return "R4";
    return (sz == 1) ? "R5" : "R6";
  endfunction

  task automatic do_reset(input bit be);
    rst_n = 0; cfg_big_endian = be; mode_be = be;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(io_req == 0, "reset io_req", io_req, 0);
    chk(cpu_done == 0, "reset cpu_done", cpu_done, 0);
    chk(cpu_rdata == 0, "reset cpu_rdata", cpu_rdata, 0);
  endtask

  task automatic access(input logic [31:0] a, input logic [1:0] sz, input bit we,
                        input logic [31:0] wd, input logic [31:0] rd, input int dly);
    bit exp_claim;
    logic [31:0] exp_rd;
    exp_claim = (a[31:16] == 16'h1400) && (sz != 3);
    @(negedge clk);
    cpu_req = 1; cpu_addr = a; cpu_size = sz; cpu_we = we; cpu_wdata = wd;
    #1;
    chk(cpu_claim == exp_claim, (sz == 3) ? "R9 claim" : "R1 claim", cpu_claim, exp_claim);
    @(negedge clk);
    cpu_req = 0;
    if (!exp_claim) begin
      chk(io_req == 0, "R1 no io_req", io_req, 0);
      return;
    end
    chk(io_req == 1, "R2 io_req", io_req, 1);
    chk(io_addr == a[15:0], "R2 io_addr", io_addr, a[15:0]);
    chk(io_size == sz && io_we == we, "R2 size/we", {io_size, io_we}, {sz, we});
    if (we) chk(io_wdata == conv(sz, mode_be, wd), tag_of(sz, mode_be), io_wdata, conv(sz, mode_be, wd));
    for (int i = 0; i < dly; i++) begin
      cpu_req = 1; cpu_addr = 32'h1400_0000 | $urandom_range(0, 16'hFFFF); cpu_size = 2'd2;
      #1;
      chk(cpu_claim == 0, "R11 claim while busy", cpu_claim, 0);
      cpu_req = 0;
      @(negedge clk);
      chk(io_req == 1 && io_addr == a[15:0] && io_size == sz, "R7 hold", io_addr, a[15:0]);
    end
    io_ack = 1; io_rdata = rd;
    @(negedge clk);
    io_ack = 0; io_rdata = $urandom;
    exp_rd = we ? 32'b0 : conv(sz, mode_be, rd);
    chk(cpu_done == 1 && io_req == 0, "R8 done", {cpu_done, io_req}, 2'b10);
    chk(cpu_rdata == exp_rd, we ? "R8 write rdata" : tag_of(sz, mode_be), cpu_rdata, exp_rd);
    @(negedge clk);
    chk(cpu_done == 0, "R8 done pulse", cpu_done, 0);
  endtask

  task automatic random_run(input int n);
    for (int i = 0; i < n; i++) begin
      logic [31:0] a;
      case ($urandom_range(0, 5))
        0: a = $urandom;
        1: a = 32'h13FF_FFFC;
        2: a = 32'h1401_0000;
        default: a = 32'h1400_0000 | $urandom_range(0, 16'hFFFF);
      endcase
      access(a, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), $urandom, $urandom, $urandom_range(0, 3));
    end
  endtask

  initial begin
    void'($urandom(32'd20250));
    do_reset(0);
    access(32'h1400_0000, 2'd0, 1, 32'hAABB_CCDD, 0, 0);
    access(32'h1400_FFFF, 2'd0, 0, 0, 32'h1122_3344, 1);
    access(32'h1400_1234, 2'd1, 1, 32'h0000_BEEF, 0, 2);
    access(32'h1400_0010, 2'd2, 0, 0, 32'h0102_0304, 0);
    access(32'h13FF_FFFF, 2'd0, 1, 32'h55, 0, 0);
    access(32'h1401_0000, 2'd1, 0, 0, 0, 0);
    access(32'h1400_0020, 2'd3, 1, 32'h1, 0, 0);
    cfg_big_endian = 1;
    access(32'h1400_0040, 2'd1, 0, 0, 32'h0000_A1B2, 0); // R10: still little-endian
    random_run(60);
    do_reset(1);
    access(32'h1400_0002, 2'd1, 1, 32'h0000_1234, 0, 1);
    access(32'h1400_0004, 2'd1, 0, 0, 32'h0000_5678, 0);
    access(32'h1400_0008, 2'd2, 1, 32'hDEAD_BEEF, 0, 0);
    access(32'h1400_000C, 2'd2, 0, 0, 32'h0102_0304, 2);
    access(32'h1400_0001, 2'd0, 0, 0, 32'hFFFF_FF9A, 0);
    cfg_big_endian = 0;
    access(32'h1400_0044, 2'd2, 0, 0, 32'hA0B0_C0D0, 0); // R10: still big-endian
    random_run(60);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule